// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns host-supplied bytes into asynchronous serial frames on one output line. The host writes a byte, or a nine-bit word, into a single-entry holding buffer. When the shift path is free, the buffer content moves into the shifter and the frame goes out one bit per sixteen pulses of an externally generated baud tick. The buffer empties and raises a one-cycle ready interrupt in the first cycle of the frame, so the host can load the next word while the current one is still on the line.

The frame shape is chosen by static configuration inputs:
- a start level and a stop level, and the line rests at the stop level between frames;
- eight data bits, sent LSB-first or MSB-first;
- an optional ninth bit, which is either the host's extra data bit or an even or odd parity bit;
- one or two stop bits.

The configuration is captured when a frame begins. An optional flow-control mode holds a pending frame back until the active-low clear-to-send input is low. Status outputs show whether a frame is on the line and whether the last frame has completed.

Top module: `uart_tx_core`

## Requirements
- R1: A frame is one start bit, eight data bits, an optional ninth bit (present when `cfg_nine`=1) and one or two stop bits. Each bit lasts exactly 16 `baud_tick` pulses. Frame length in bits is 10 + `cfg_nine` + `cfg_two_stop`.
- R2: With `cfg_two_stop`=1 the frame ends with two stop bits. With `cfg_two_stop`=0 it ends with one.
- R3: When `cfg_nine`=1 and `cfg_par_en`=1, the ninth bit is parity. Even parity (`cfg_par_odd`=0) sends the XOR of the eight data bits. Odd parity sends its inverse. When `cfg_nine`=1 and `cfg_par_en`=0, the ninth bit is `wr_data[8]`.
- R4: With `cfg_msb_first`=0 the data bits go out as `wr_data[0]` first, up to `wr_data[7]`. With `cfg_msb_first`=1 they go out from `wr_data[7]` down to `wr_data[0]`. The ninth bit always follows the eight data bits.
- R5: The start bit is driven at `cfg_start_lvl` and each stop bit at `cfg_stop_lvl`. When no frame is active, including in reset, `txd` equals `cfg_stop_lvl`.
- R6: A write sets `buf_full`. A frame starts on the clock edge after the buffer is full and the shifter is idle. In the first cycle with `tx_active` high, `buf_full` is low and `buf_irq` is high for that one cycle. Reset clears `buf_full` and `buf_irq`.
- R7: A word written while a frame is in progress is held. It starts after exactly one idle cycle once the current frame ends.
- R8: `tx_active` rises in the first cycle of the start bit and falls when the last stop bit ends. With a tick on every cycle, it stays high for 16 × frame-length cycles.
- R9: `tx_done` is set in the cycle `tx_active` falls. It is cleared by a write (`wr_en`) or a status read (`status_rd`). Reset clears it.
- R10: With `cfg_flow_en`=1, a pending frame does not start while `cts_n` is high, and it starts once `cts_n` goes low. With `cfg_flow_en`=0, `cts_n` has no effect.
- R11: `txd` changes during a frame only on a clock edge where `baud_tick` was high, so the bit time scales with the tick rate.
- R12: The format is captured at frame start. Changing the start level, bit order, ninth-bit or stop-count inputs during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse at 16× the bit rate |
| wr_en | input | 1 | Write strobe into the holding buffer |
| wr_data | input | 9 | Word to send; bit 8 is the ninth data bit |
| status_rd | input | 1 | Status read strobe; clears `tx_done` |
| cfg_nine | input | 1 | Enable ninth bit |
| cfg_par_en | input | 1 | Ninth bit carries parity |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| cfg_start_lvl | input | 1 | Line level of the start bit |
| cfg_stop_lvl | input | 1 | Line level of stop bits and idle |
| cfg_msb_first | input | 1 | 1 = data MSB first |
| cfg_flow_en | input | 1 | Enable clear-to-send gating |
| cts_n | input | 1 | Clear to send, active low |
| txd | output | 1 | Serial line |
| buf_full | output | 1 | Holding buffer occupied |
| buf_irq | output | 1 | One-cycle buffer-ready pulse at frame start |
| tx_active | output | 1 | Frame on the line |
| tx_done | output | 1 | Last frame completed |

## Verification
The assertions assume that `cfg_stop_lvl` does not change in the cycle a frame ends. The idle-level property is guarded on that, and the bench changes configuration only between frames or, for the capture test, leaves the stop level alone. They also assume that `baud_tick` is a single-cycle strobe. The bench drives it either on every cycle or on alternate cycles. Writes are issued only while the holding buffer is empty, so no pending word is overwritten during the sweeps over all 128 format combinations.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    parameter int DATA_W = 8;
    localparam int FRAME_MAX = DATA_W + 4;
    localparam int LEN_W = $clog2(FRAME_MAX + 1);

    typedef struct packed {
        logic nine;
        logic par_en;
        logic par_odd;
        logic two_stop;
        logic start_lvl;
        logic stop_lvl;
        logic msb_first;
    } fmt_t;

    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;
        logic [LEN_W-1:0]     len;
    } frame_t;

    function automatic logic [DATA_W-1:0] order_data(input logic [DATA_W-1:0] d,
                                                     input logic msb);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++)
            r[i] = msb ? d[DATA_W-1-i] : d[i];
        return r;
    endfunction

    function automatic logic ninth_bit(input fmt_t f, input logic [DATA_W:0] w);
        if (f.par_en)
            return f.par_odd ? ~(^w[DATA_W-1:0]) : ^w[DATA_W-1:0];
        return w[DATA_W];
    endfunction

    // Bit 0 of the vector leaves the line first.
    function automatic frame_t build_frame(input fmt_t f, input logic [DATA_W:0] w);
        frame_t fr;
        fr.bits = {FRAME_MAX{f.stop_lvl}};
        fr.bits[0] = f.start_lvl;
        fr.bits[DATA_W:1] = order_data(w[DATA_W-1:0], f.msb_first);
        if (f.nine)
            fr.bits[DATA_W+1] = ninth_bit(f, w);
        fr.len = LEN_W'(DATA_W + 2) + LEN_W'(f.nine) + LEN_W'(f.two_stop);
        return fr;
    endfunction

endpackage

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer #(
    parameter int TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic bit_end
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (run && tick)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    assign bit_end = run && tick && (cnt_q == LAST);
endmodule

// File: rtl/uart_tx_hold_buf.sv
module uart_tx_hold_buf #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] data
);
    logic         full_q;
    logic [W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (take)
                full_q <= 1'b0;
            if (wr_en) begin
                full_q <= 1'b1;
                data_q <= wr_data;
            end
        end
    end

    assign full = full_q;
    assign data = data_q;
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  frame_t frame,
    input  logic   idle_lvl,
    input  logic   bit_end,
    output logic   txd,
    output logic   busy,
    output logic   finish
);
    logic                 busy_q;
    logic                 cur_q;
    logic [FRAME_MAX-1:0] sh_q;
    logic [LEN_W-1:0]     left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cur_q  <= 1'b0;
            sh_q   <= '0;
            left_q <= '0;
        end else if (load) begin
            busy_q <= 1'b1;
            cur_q  <= frame.bits[0];
            sh_q   <= frame.bits >> 1;
            left_q <= frame.len - LEN_W'(1);
        end else if (busy_q && bit_end) begin
            if (left_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cur_q  <= sh_q[0];
                sh_q   <= sh_q >> 1;
                left_q <= left_q - LEN_W'(1);
            end
        end
    end

    assign finish = busy_q && bit_end && (left_q == '0);
    assign busy   = busy_q;
    assign txd    = busy_q ? cur_q : idle_lvl;
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
    import uart_tx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [DATA_W:0]   wr_data,
    input  logic              status_rd,
    input  logic              cfg_nine,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic              cfg_start_lvl,
    input  logic              cfg_stop_lvl,
    input  logic              cfg_msb_first,
    input  logic              cfg_flow_en,
    input  logic              cts_n,
    output logic              txd,
    output logic              buf_full,
    output logic              buf_irq,
    output logic              tx_active,
    output logic              tx_done
);
    fmt_t            fmt;
    frame_t          frame;
    logic [DATA_W:0] hold_data;
    logic            hold_full;
    logic            busy;
    logic            start;
    logic            bit_end;
    logic            finish;
    logic            irq_q;
    logic            done_q;

    assign fmt = '{nine: cfg_nine, par_en: cfg_par_en, par_odd: cfg_par_odd,
                   two_stop: cfg_two_stop, start_lvl: cfg_start_lvl,
                   stop_lvl: cfg_stop_lvl, msb_first: cfg_msb_first};

    assign frame = build_frame(fmt, hold_data);
    assign start = !busy && hold_full && (!cfg_flow_en || !cts_n);

    uart_tx_hold_buf #(.W(DATA_W + 1)) u_hold (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .take(start), .full(hold_full), .data(hold_data)
    );

    uart_tx_bit_timer #(.TICKS(TICKS_PER_BIT)) u_timer (
        .clk(clk), .rst(rst), .clear(start), .run(busy),
        .tick(baud_tick), .bit_end(bit_end)
    );

    uart_tx_shifter u_shift (
        .clk(clk), .rst(rst), .load(start), .frame(frame),
        .idle_lvl(cfg_stop_lvl), .bit_end(bit_end),
        .txd(txd), .busy(busy), .finish(finish)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            irq_q <= start;
            if (finish)
                done_q <= 1'b1;
            else if (wr_en || status_rd)
                done_q <= 1'b0;
        end
    end

    assign buf_full  = hold_full;
    assign buf_irq   = irq_q;
    assign tx_active = busy;
    assign tx_done   = done_q;
endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk (
    input logic clk,
    input logic rst,
    input logic baud_tick,
    input logic wr_en,
    input logic status_rd,
    input logic cfg_flow_en,
    input logic cfg_start_lvl,
    input logic cfg_stop_lvl,
    input logic cts_n,
    input logic txd,
    input logic buf_full,
    input logic buf_irq,
    input logic tx_active,
    input logic tx_done
);
    // R10
    cts_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_active) |-> (!$past(cfg_flow_en) || !$past(cts_n)));

    // R6
    irq_at_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_active) |-> buf_irq);

    // R6
    irq_only_active_chk: assert property (@(posedge clk) disable iff (rst)
        buf_irq |-> tx_active);

    // R6
    buf_drained_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(tx_active) && !$past(wr_en)) |-> !buf_full);

    // R5
    start_level_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_active) |-> (txd == $past(cfg_start_lvl)));

    // R5
    idle_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(tx_active) && $stable(cfg_stop_lvl)) |-> $stable(txd));

    // R9
    done_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_done) |-> $fell(tx_active));

    // R9
    done_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_done && status_rd && !tx_active) |=> !tx_done);

    // R11
    tick_paced_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_active && $past(tx_active) && !$past(baud_tick)) |-> $stable(txd));
endmodule

bind uart_tx_core uart_tx_chk u_chk (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_en(wr_en),
    .status_rd(status_rd), .cfg_flow_en(cfg_flow_en),
    .cfg_start_lvl(cfg_start_lvl), .cfg_stop_lvl(cfg_stop_lvl),
    .cts_n(cts_n), .txd(txd), .buf_full(buf_full), .buf_irq(buf_irq),
    .tx_active(tx_active), .tx_done(tx_done)
);

// File: tb/uart_tx_core_bench.sv
`timescale 1ns/1ps
module uart_tx_core_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       status_rd = 1'b0;
    logic       cfg_nine = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic       cfg_two_stop = 1'b0, cfg_start_lvl = 1'b0, cfg_stop_lvl = 1'b0;
    logic       cfg_msb_first = 1'b0, cfg_flow_en = 1'b0, cts_n = 1'b1;
    logic       txd, buf_full, buf_irq, tx_active, tx_done;
    logic       sparse = 1'b0;
    int         checks = 0;
    int         errors = 0;

    always #10 clk = ~clk;

    uart_tx_core u_uart_tx_core (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_en(wr_en),
        .wr_data(wr_data), .status_rd(status_rd), .cfg_nine(cfg_nine),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .cfg_start_lvl(cfg_start_lvl),
        .cfg_stop_lvl(cfg_stop_lvl), .cfg_msb_first(cfg_msb_first),
        .cfg_flow_en(cfg_flow_en), .cts_n(cts_n), .txd(txd),
        .buf_full(buf_full), .buf_irq(buf_irq), .tx_active(tx_active),
        .tx_done(tx_done)
    );

    initial begin
        forever begin
            @(negedge clk);
            baud_tick <= sparse ? ~baud_tick : 1'b1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // format code bits: 0 nine, 1 par_en, 2 par_odd, 3 two_stop,
    // 4 start level, 5 stop level, 6 msb first
    task automatic set_cfg(input int c);
        cfg_nine      = c[0];
        cfg_par_en    = c[1];
        cfg_par_odd   = c[2];
        cfg_two_stop  = c[3];
        cfg_start_lvl = c[4];
        cfg_stop_lvl  = c[5];
        cfg_msb_first = c[6];
    endtask

    task automatic exp_frame(input int c, input logic [8:0] w,
                             output logic [11:0] b, output int n);
        logic [7:0] d;
        d = w[7:0];
        b = '0;
        n = 0;
        b[n] = c[4]; n++;
        for (int i = 0; i < 8; i++) begin
            b[n] = c[6] ? d[7-i] : d[i];
            n++;
        end
        if (c[0]) begin
            if (c[1]) b[n] = c[2] ? ~(^d) : (^d);
            else      b[n] = w[8];
            n++;
        end
        b[n] = c[5]; n++;
        if (c[3]) begin
            b[n] = c[5]; n++;
        end
    endtask

    task automatic write_word(input logic [8:0] w);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_active(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (tx_active) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    // Entered at the negedge of the first active cycle.
    task automatic capture(input int bc, output logic [11:0] got, output int cyc);
        got = '0;
        cyc = 0;
        while (tx_active) begin
            if ((cyc % bc) == bc / 2 && (cyc / bc) < 12)
                got[cyc / bc] = txd;
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic run_frame(input int c, input logic [8:0] w, input string tag);
        logic [11:0] eb, got;
        int n, cyc;
        bit ok;
        set_cfg(c);
        write_word(w);
        chk(buf_full == 1'b1, "R6 buf_full after write", int'(buf_full), 1);
        chk(tx_done == 1'b0, "R9 done cleared by write", int'(tx_done), 0);
        wait_active(ok);
        chk(ok, "R6 frame start", int'(ok), 1);
        chk(buf_irq == 1'b1 && buf_full == 1'b0, "R6 irq and drain at start",
            int'({buf_irq, buf_full}), 2);
        exp_frame(c, w, eb, n);
        capture(16, got, cyc);
        chk((got & ((12'h1 << n) - 1)) == eb, tag, int'(got), int'(eb));
        chk(cyc == 16 * n, "R1 R8 active length", cyc, 16 * n);
        chk(tx_done == 1'b1, "R9 done at end", int'(tx_done), 1);
        chk(txd == c[5], "R5 idle at stop level", int'(txd), int'(c[5]));
    endtask

    initial begin
        logic [11:0] eb, got;
        int n, cyc, gap;
        bit ok;

        repeat (5) @(negedge clk);
        chk(txd == 1'b0 && tx_active == 1'b0, "R5 reset line and active",
            int'({txd, tx_active}), 0);
        chk(buf_full == 1'b0 && buf_irq == 1'b0 && tx_done == 1'b0,
            "R6 R9 reset flags", int'({buf_full, buf_irq, tx_done}), 0);
        cfg_stop_lvl = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1, "R5 reset idle follows stop level", int'(txd), 1);
        rst = 1'b0;

        // Sweep every format with two data words each.
        for (int c = 0; c < 128; c++) begin
            for (int p = 0; p < 2; p++) begin
                logic [8:0] w;
                w = 9'(c * 37 + 11 + p * 301);
                run_frame(c, w, "R1 R2 R3 R4 R5 frame bits");
            end
        end

        // R9: a status read clears done.
        chk(tx_done == 1'b1, "R9 done before read", int'(tx_done), 1);
        @(negedge clk); status_rd = 1'b1;
        @(negedge clk); status_rd = 1'b0;
        chk(tx_done == 1'b0, "R9 status read clears done", int'(tx_done), 0);

        // R7: second word written mid-frame follows after one idle cycle.
        set_cfg(32);
        write_word(9'h0A5);
        wait_active(ok);
        write_word(9'h13C);
        chk(buf_full == 1'b1, "R7 word held mid-frame", int'(buf_full), 1);
        exp_frame(32, 9'h0A5, eb, n);
        capture(16, got, cyc);
        chk((got & ((12'h1 << n) - 1)) == eb, "R7 first frame", int'(got), int'(eb));
        gap = 0;
        while (!tx_active && gap < 100) begin
            gap++;
            @(negedge clk);
        end
        chk(gap == 1, "R7 one idle cycle between frames", gap, 1);
        exp_frame(32, 9'h13C, eb, n);
        capture(16, got, cyc);
        chk((got & ((12'h1 << n) - 1)) == eb, "R7 second frame", int'(got), int'(eb));

        // R11: ticks on alternate cycles double the bit time.
        sparse = 1'b1;
        set_cfg(7'h6B);
        write_word(9'h1C3);
        wait_active(ok);
        exp_frame(7'h6B, 9'h1C3, eb, n);
        capture(32, got, cyc);
        chk((got & ((12'h1 << n) - 1)) == eb, "R11 frame at half tick rate",
            int'(got), int'(eb));
        chk(cyc >= 32 * n - 1 && cyc <= 32 * n + 1, "R11 bit time follows tick",
            cyc, 32 * n);
        sparse = 1'b0;

        // R10: flow control holds the frame while cts_n is high.
        set_cfg(32);
        cfg_flow_en = 1'b1;
        cts_n = 1'b1;
        write_word(9'h05A);
        repeat (200) @(negedge clk);
        chk(tx_active == 1'b0 && buf_full == 1'b1 && txd == 1'b1,
            "R10 held while cts_n high", int'({tx_active, buf_full, txd}), 3);
        cts_n = 1'b0;
        wait_active(ok);
        chk(ok, "R10 starts when cts_n low", int'(ok), 1);
        exp_frame(32, 9'h05A, eb, n);
        capture(16, got, cyc);
        chk((got & ((12'h1 << n) - 1)) == eb, "R10 gated frame", int'(got), int'(eb));
        cfg_flow_en = 1'b0;
        cts_n = 1'b1;
        write_word(9'h0F0);
        wait_active(ok);
        chk(ok, "R10 cts_n ignored without flow control", int'(ok), 1);
        capture(16, got, cyc);

        // R12: format changes during a frame do not alter it.
        set_cfg(7'h29);
        write_word(9'h1E1);
        wait_active(ok);
        @(negedge clk);
        cfg_start_lvl = 1'b1;
        cfg_msb_first = 1'b1;
        cfg_nine = 1'b0;
        cfg_two_stop = 1'b0;
        exp_frame(7'h29, 9'h1E1, eb, n);
        capture(16, got, cyc);
        got[0] = 1'b0;
        chk((got & ((12'h1 << n) - 1)) == eb, "R12 format captured at start",
            int'(got), int'(eb));
        chk(cyc == 16 * n - 1, "R12 length kept", cyc, 16 * n - 1);

        finish_run();
    end
endmodule